// File: doc/BRIEF.md
# Output Colour-Space Matrix (RGB to YCbCr)

This block sits at the output of a display pipeline. It turns each 8-bit RGB pixel into a luma/chroma triple by passing it through a programmable 3x4 matrix. Every output channel is a weighted sum of the three input channels plus an offset. The result is rounded down and then clamped to the 8-bit range.

A simple write port loads twelve matrix words and one enable bit. Words written there land in a staging copy. The datapath switches to the staging copy only when a pixel that starts a frame enters the block, so no frame is ever converted with a mix of old and new settings.

The pixel stream carries a valid flag, a start-of-frame flag and an end-of-line flag. The block re-times all three with the pixel data. When conversion is off, the input pixel comes out unchanged with the same delay, so the downstream timing never depends on the mode.

Top module: `csc_out_matrix`

## Requirements
- R1: The data, `out_valid`, `out_sof` and `out_eol` on the output are the input values from exactly 3 clock cycles earlier. No pixel is dropped, duplicated or reordered.
- R2: When conversion is active, each channel equals clamp(floor((R*wr + G*wg + B*wb + K*64) / 1024)).
  - wr, wg and wb are 14-bit two's complement weights scaled by 1024.
  - K is a 14-bit unsigned offset scaled by 16.
- R3: Word address 4*row + col holds the weight for R (col 0), G (col 1) or B (col 2), or the offset (col 3). Row 0 drives `out_c0` (Y), row 1 drives `out_c1` (Cb) and row 2 drives `out_c2` (Cr).
- R4: A sum below zero gives 0 and a floored sum above 255 gives 255.
- R5: When the enable bit (address 12, data bit 0) is 0, the outputs are `in_r`, `in_g` and `in_b` unchanged, with the 3-cycle latency.
- R6: After synchronous reset:
  - the enable bit is 0;
  - the three output flags are 0;
  - rows 0, 1 and 2 hold (0x107, 0x204, 0x064, 0x108), (0x3F69, 0x3ED6, 0x1C1, 0x808) and (0x1C1, 0x3E88, 0x3FB8, 0x808) respectively.
- R7: Writes change only the staging copy. The active weights and enable bit are replaced on a cycle where `in_valid` and `in_sof` are both 1, and that pixel already uses the new values. Pixels after a mid-frame write keep the old values.
- R8: Writing the enable bit leaves every weight unchanged, so turning conversion off and back on reproduces the earlier results.
- R9: Writes to addresses 13 to 15 change neither the weights nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 4 | Word address: 0-11 matrix, 12 enable, 13-15 unused |
| cfg_wdata | input | 14 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input start of frame |
| in_eol | input | 1 | Input end of line |
| in_r | input | 8 | Red |
| in_g | input | 8 | Green |
| in_b | input | 8 | Blue |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output start of frame |
| out_eol | output | 1 | Output end of line |
| out_c0 | output | 8 | Y, or red in bypass |
| out_c1 | output | 8 | Cb, or green in bypass |
| out_c2 | output | 8 | Cr, or blue in bypass |

## Verification
The embedded properties check several things on every cycle:
- the three-cycle flag alignment;
- the clamp outcome of every row whenever its floored sum leaves the 8-bit range;
- the bypass copy;
- that the active set moves only on a frame-start pixel;
- that writes to the enable bit or to the spare addresses leave the weights untouched.

The arithmetic of the matrix itself, the mapping of addresses to rows and columns, and the reset values can only be shown by the bench's scenarios. These are dense sweeps whose expected values the bench computes from the formula. Only scenarios can also show that a mid-frame write stays invisible until the next frame, and that weights survive a disable and re-enable.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int CSC_PIX_W   = 8;
    localparam int CSC_COEF_W  = 14;
    localparam int CSC_FRAC_W  = 10;
    localparam int CSC_K_FRAC  = 4;
    localparam int CSC_ADDR_W  = 4;
    localparam int CSC_NROW    = 3;
    localparam int CSC_NCOL    = 4;
    localparam int CSC_LATENCY = 3;

    // Stream side-band carried alongside each pixel
    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
    } csc_ctl_t;

    // Power-up matrix: rows Y, Cb, Cr; columns R, G, B, offset
    function automatic logic [CSC_COEF_W-1:0] csc_default_word(input int unsigned idx);
        logic [CSC_COEF_W-1:0] w;
        case (idx)
            0:       w = 14'h0107;
            1:       w = 14'h0204;
            2:       w = 14'h0064;
            3:       w = 14'h0108;
            4:       w = 14'h3F69;
            5:       w = 14'h3ED6;
            6:       w = 14'h01C1;
            7:       w = 14'h0808;
            8:       w = 14'h01C1;
            9:       w = 14'h3E88;
            10:      w = 14'h3FB8;
            11:      w = 14'h0808;
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
#(
    parameter int COEF_W = CSC_COEF_W,
    parameter int ADDR_W = CSC_ADDR_W,
    parameter int NREG   = CSC_NROW * CSC_NCOL
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [COEF_W-1:0]          wr_data,
    input  logic                       frame_load,
    output logic [NREG-1:0][COEF_W-1:0] coef_eff,
    output logic                       conv_eff
);

    localparam int CTRL_ADDR = NREG;

    logic [NREG-1:0][COEF_W-1:0] shadow_q;
    logic [NREG-1:0][COEF_W-1:0] active_q;
    logic                        en_sh_q;
    logic                        en_act_q;

    // Staging copy: written by the configuration port
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                shadow_q[i] <= COEF_W'(csc_default_word(i));
            end
            en_sh_q <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    shadow_q[i] <= wr_data;
                end
            end
            if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                en_sh_q <= wr_data[0];
            end
        end
    end

    // Active copy: swapped in only at a frame start
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                active_q[i] <= COEF_W'(csc_default_word(i));
            end
            en_act_q <= 1'b0;
        end else if (frame_load) begin
            active_q <= shadow_q;
            en_act_q <= en_sh_q;
        end
    end

    // The frame-start pixel itself must see the new set
    assign coef_eff = frame_load ? shadow_q : active_q;
    assign conv_eff = frame_load ? en_sh_q  : en_act_q;

    assert_active_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !frame_load |=> ($stable(active_q) && $stable(en_act_q)));

    assert_active_take_R7: assert property (@(posedge clk) disable iff (rst)
        frame_load |=> (active_q == $past(shadow_q)));

    assert_ctrl_keeps_coef_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(shadow_q));

    assert_spare_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_W'(CTRL_ADDR)) |=> ($stable(shadow_q) && $stable(en_sh_q)));

endmodule

// File: rtl/csc_mac_row.sv
module csc_mac_row
    import csc_pkg::*;
#(
    parameter int PIX_W  = CSC_PIX_W,
    parameter int COEF_W = CSC_COEF_W,
    parameter int FRAC_W = CSC_FRAC_W,
    parameter int K_FRAC = CSC_K_FRAC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix_r,
    input  logic [PIX_W-1:0]  pix_g,
    input  logic [PIX_W-1:0]  pix_b,
    input  logic [PIX_W-1:0]  pix_raw,
    input  logic [COEF_W-1:0] w_r,
    input  logic [COEF_W-1:0] w_g,
    input  logic [COEF_W-1:0] w_b,
    input  logic [COEF_W-1:0] w_k,
    input  logic              conv_en,
    output logic [PIX_W-1:0]  pix_out
);

    localparam int PROD_W = PIX_W + COEF_W + 1;
    localparam int ACC_W  = PROD_W + 2;
    localparam int Q_W    = ACC_W - FRAC_W;
    localparam int K_SH   = FRAC_W - K_FRAC;
    localparam int NPROD  = 3;

    function automatic logic signed [PROD_W-1:0] smul(input logic [PIX_W-1:0] p,
                                                      input logic [COEF_W-1:0] w);
        logic signed [PROD_W-1:0] a;
        logic signed [PROD_W-1:0] b;
        a = PROD_W'(signed'({1'b0, p}));
        b = PROD_W'(signed'(w));
        return a * b;
    endfunction

    logic [NPROD-1:0][PIX_W-1:0]  pix_in;
    logic [NPROD-1:0][COEF_W-1:0] w_in;

    assign pix_in = {pix_b, pix_g, pix_r};
    assign w_in   = {w_b, w_g, w_r};

    // Stage 1: products and aligned offset
    logic signed [PROD_W-1:0] prod_s1 [NPROD];
    logic signed [ACC_W-1:0]  k_s1;
    logic [PIX_W-1:0]         raw_s1;
    logic                     conv_s1;

    for (genvar p = 0; p < NPROD; p++) begin : g_mul
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_s1[p] <= '0;
            end else begin
                prod_s1[p] <= smul(pix_in[p], w_in[p]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_s1    <= '0;
            raw_s1  <= '0;
            conv_s1 <= 1'b0;
        end else begin
            k_s1    <= signed'(ACC_W'({w_k, {K_SH{1'b0}}}));
            raw_s1  <= pix_raw;
            conv_s1 <= conv_en;
        end
    end

    // Stage 2: sum and floor
    logic signed [ACC_W-1:0] sum_c;
    logic signed [Q_W-1:0]   q_s2;
    logic [PIX_W-1:0]        raw_s2;
    logic                    conv_s2;

    always_comb begin
        sum_c = k_s1;
        for (int p = 0; p < NPROD; p++) begin
            sum_c = sum_c + ACC_W'(prod_s1[p]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_s2    <= '0;
            raw_s2  <= '0;
            conv_s2 <= 1'b0;
        end else begin
            q_s2    <= Q_W'(sum_c >>> FRAC_W);
            raw_s2  <= raw_s1;
            conv_s2 <= conv_s1;
        end
    end

    // Stage 3: clamp and bypass select
    logic [PIX_W-1:0] sat_c;

    always_comb begin
        if (q_s2[Q_W-1]) begin
            sat_c = '0;
        end else if (|q_s2[Q_W-2:PIX_W]) begin
            sat_c = '1;
        end else begin
            sat_c = q_s2[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
        end else begin
            pix_out <= conv_s2 ? sat_c : raw_s2;
        end
    end

    assert_clamp_low_R4: assert property (@(posedge clk) disable iff (rst)
        (conv_s2 && q_s2[Q_W-1]) |=> (pix_out == '0));

    assert_clamp_high_R4: assert property (@(posedge clk) disable iff (rst)
        (conv_s2 && !q_s2[Q_W-1] && (|q_s2[Q_W-2:PIX_W])) |=> (pix_out == '1));

    assert_bypass_copy_R5: assert property (@(posedge clk) disable iff (rst)
        !conv_s2 |=> (pix_out == $past(raw_s2)));

endmodule

// File: rtl/csc_out_matrix.sv
module csc_out_matrix
    import csc_pkg::*;
#(
    parameter int PIX_W  = CSC_PIX_W,
    parameter int COEF_W = CSC_COEF_W,
    parameter int FRAC_W = CSC_FRAC_W,
    parameter int K_FRAC = CSC_K_FRAC,
    parameter int ADDR_W = CSC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eol,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2
);

    localparam int NROW   = CSC_NROW;
    localparam int NCOL   = CSC_NCOL;
    localparam int NREG   = NROW * NCOL;
    localparam int PIPE_D = CSC_LATENCY;

    logic                        frame_load;
    logic [NREG-1:0][COEF_W-1:0] coef_eff;
    logic                        conv_eff;

    assign frame_load = in_valid & in_sof;

    csc_coef_bank #(
        .COEF_W (COEF_W),
        .ADDR_W (ADDR_W),
        .NREG   (NREG)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we),
        .wr_addr    (cfg_addr),
        .wr_data    (cfg_wdata),
        .frame_load (frame_load),
        .coef_eff   (coef_eff),
        .conv_eff   (conv_eff)
    );

    logic [NROW-1:0][PIX_W-1:0] raw_in;
    logic [NROW-1:0][PIX_W-1:0] row_out;

    assign raw_in = {in_b, in_g, in_r};

    for (genvar rw = 0; rw < NROW; rw++) begin : g_row
        csc_mac_row #(
            .PIX_W  (PIX_W),
            .COEF_W (COEF_W),
            .FRAC_W (FRAC_W),
            .K_FRAC (K_FRAC)
        ) u_row (
            .clk     (clk),
            .rst     (rst),
            .pix_r   (in_r),
            .pix_g   (in_g),
            .pix_b   (in_b),
            .pix_raw (raw_in[rw]),
            .w_r     (coef_eff[rw*NCOL + 0]),
            .w_g     (coef_eff[rw*NCOL + 1]),
            .w_b     (coef_eff[rw*NCOL + 2]),
            .w_k     (coef_eff[rw*NCOL + 3]),
            .conv_en (conv_eff),
            .pix_out (row_out[rw])
        );
    end

    // Side-band delay line matching the datapath depth
    csc_ctl_t ctl_q [PIPE_D];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_D; i++) begin
                ctl_q[i] <= '0;
            end
        end else begin
            ctl_q[0] <= '{valid: in_valid, sof: in_sof, eol: in_eol};
            for (int i = 1; i < PIPE_D; i++) begin
                ctl_q[i] <= ctl_q[i-1];
            end
        end
    end

    assign out_valid = ctl_q[PIPE_D-1].valid;
    assign out_sof   = ctl_q[PIPE_D-1].sof;
    assign out_eol   = ctl_q[PIPE_D-1].eol;
    assign out_c0    = row_out[0];
    assign out_c1    = row_out[1];
    assign out_c2    = row_out[2];

    // Cycles since reset release, saturating at the pipeline depth
    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assert_flag_delay_R1: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> ({out_valid, out_sof, out_eol} == $past({in_valid, in_sof, in_eol}, 3)));

endmodule

// File: tb/csc_out_matrix_tb.sv
module csc_out_matrix_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eol = 1'b0;
    logic [7:0]  in_r = '0;
    logic [7:0]  in_g = '0;
    logic [7:0]  in_b = '0;
    logic        out_valid;
    logic        out_sof;
    logic        out_eol;
    logic [7:0]  out_c0;
    logic [7:0]  out_c1;
    logic [7:0]  out_c2;

    always #2 clk = ~clk;

    csc_out_matrix dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .in_r      (in_r),
        .in_g      (in_g),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eol   (out_eol),
        .out_c0    (out_c0),
        .out_c1    (out_c1),
        .out_c2    (out_c2)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Bench model of the staging and active sets
    int sh [12];
    int act [12];
    int sh_en = 0;
    int act_en = 0;

    // Expected output queue
    int    eq_cyc [$];
    int    eq_c0 [$];
    int    eq_c1 [$];
    int    eq_c2 [$];
    int    eq_sof [$];
    int    eq_eol [$];
    string eq_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act_v, exp_v);
        end
    endtask

    function automatic int sx14(input int v);
        return (v >= 8192) ? v - 16384 : v;
    endfunction

    function automatic int model_row(input int row, input int r, input int g, input int b);
        int s;
        int q;
        s = r * sx14(act[row*4]) + g * sx14(act[row*4+1]) + b * sx14(act[row*4+2])
            + act[row*4+3] * 64;
        q = s >>> 10;
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return q;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            in_valid = 1'b0;
            in_sof = 1'b0;
            in_eol = 1'b0;
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_eol = 1'b0;
        cfg_we = 1'b1;
        cfg_addr = 4'(addr);
        cfg_wdata = 14'(data);
        if (addr < 12) sh[addr] = data & 16'h3FFF;
        else if (addr == 12) sh_en = data & 1;
    endtask

    task automatic wr_row(input int row, input int a, input int b, input int c, input int k);
        wr(row*4, a);
        wr(row*4+1, b);
        wr(row*4+2, c);
        wr(row*4+3, k);
    endtask

    task automatic pix(input int r, input int g, input int b, input bit sof,
                       input bit eol, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        in_valid = 1'b1;
        in_sof = sof;
        in_eol = eol;
        in_r = 8'(r);
        in_g = 8'(g);
        in_b = 8'(b);
        if (sof) begin
            for (int i = 0; i < 12; i++) act[i] = sh[i];
            act_en = sh_en;
        end
        eq_cyc.push_back(cyc + 3);
        if (act_en != 0) begin
            eq_c0.push_back(model_row(0, r, g, b));
            eq_c1.push_back(model_row(1, r, g, b));
            eq_c2.push_back(model_row(2, r, g, b));
        end else begin
            eq_c0.push_back(r);
            eq_c1.push_back(g);
            eq_c2.push_back(b);
        end
        eq_sof.push_back(int'(sof));
        eq_eol.push_back(int'(eol));
        eq_tag.push_back(tag);
    endtask

    // Output monitor, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            if (out_valid) begin
                if (eq_cyc.size() == 0) begin
                    chk(1'b0, "R1", "unexpected valid", 1, 0);
                end else begin
                    int    ec;
                    string tg;
                    ec = eq_cyc.pop_front();
                    tg = eq_tag.pop_front();
                    chk(ec == cyc, "R1", "output cycle", cyc, ec);
                    chk(int'(out_sof) == eq_sof[0], "R1", "sof flag", int'(out_sof), eq_sof[0]);
                    chk(int'(out_eol) == eq_eol[0], "R1", "eol flag", int'(out_eol), eq_eol[0]);
                    chk(int'(out_c0) == eq_c0[0], tg, "channel 0", int'(out_c0), eq_c0[0]);
                    chk(int'(out_c1) == eq_c1[0], tg, "channel 1", int'(out_c1), eq_c1[0]);
                    chk(int'(out_c2) == eq_c2[0], tg, "channel 2", int'(out_c2), eq_c2[0]);
                    void'(eq_sof.pop_front());
                    void'(eq_eol.pop_front());
                    void'(eq_c0.pop_front());
                    void'(eq_c1.pop_front());
                    void'(eq_c2.pop_front());
                end
            end else if (eq_cyc.size() != 0 && eq_cyc[0] <= cyc) begin
                chk(1'b0, "R1", "missing valid", 0, 1);
                void'(eq_cyc.pop_front());
                void'(eq_tag.pop_front());
                void'(eq_sof.pop_front());
                void'(eq_eol.pop_front());
                void'(eq_c0.pop_front());
                void'(eq_c1.pop_front());
                void'(eq_c2.pop_front());
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        sh[0] = 'h107;  sh[1] = 'h204;  sh[2] = 'h064;  sh[3] = 'h108;
        sh[4] = 'h3F69; sh[5] = 'h3ED6; sh[6] = 'h1C1;  sh[7] = 'h808;
        sh[8] = 'h1C1;  sh[9] = 'h3E88; sh[10] = 'h3FB8; sh[11] = 'h808;
        for (int i = 0; i < 12; i++) act[i] = sh[i];

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R6: outputs cleared by reset
        chk(out_valid == 1'b0, "R6", "out_valid after reset", int'(out_valid), 0);
        chk(out_sof == 1'b0, "R6", "out_sof after reset", int'(out_sof), 0);
        chk(out_eol == 1'b0, "R6", "out_eol after reset", int'(out_eol), 0);

        // R6: enable clear after reset -> pass-through
        for (int i = 0; i < 16; i++) pix(i * 16, 255 - i * 9, i * 5, i == 0, i == 15, "R6");
        idle(3);

        // R2: default matrix, coarse 3-D grid with gaps between lines
        wr(12, 1);
        for (int r = 0; r < 6; r++) begin
            for (int g = 0; g < 6; g++) begin
                for (int b = 0; b < 6; b++) begin
                    pix(r * 51, g * 51, b * 51, (r == 0 && g == 0 && b == 0), b == 5, "R2");
                end
                idle(1);
            end
        end

        // R6: default values over a full grey ramp
        for (int v = 0; v < 256; v++) pix(v, v, v, v == 0, v == 255, "R6");
        idle(2);

        // R3: permutation rows reveal the address map
        wr_row(0, 'h000, 'h000, 'h400, 'h000);
        wr_row(1, 'h400, 'h000, 'h000, 'h000);
        wr_row(2, 'h000, 'h400, 'h000, 'h000);
        for (int i = 0; i < 64; i++) pix(i * 4, 255 - i, (i * 7) % 256, i == 0, i == 63, "R3");
        idle(2);

        // R4: saturation at both ends
        wr_row(0, 'h1FFF, 'h1FFF, 'h1FFF, 'h3FFF);
        wr_row(1, 'h2000, 'h2000, 'h2000, 'h0000);
        wr_row(2, 'h0400, 'h3C00, 'h0000, 'h0008);
        for (int r = 0; r < 16; r++) begin
            for (int g = 0; g < 16; g++) begin
                pix(r * 17, g * 17, (r + g) * 8, (r == 0 && g == 0), g == 15, "R4");
            end
        end
        idle(2);

        // R7: mid-frame writes stay hidden until the next frame start
        for (int i = 0; i < 10; i++) pix(i * 20, i * 3, 200 - i, i == 0, 1'b0, "R7");
        wr_row(0, 'h0200, 'h0100, 'h0080, 'h0020);
        wr_row(1, 'h3E00, 'h0300, 'h0000, 'h0800);
        wr_row(2, 'h0000, 'h0000, 'h0600, 'h0010);
        wr(12, 0);
        for (int i = 0; i < 10; i++) pix(255 - i * 20, i * 11, i, 1'b0, i == 9, "R7");
        idle(1);

        // R5: new frame now in bypass
        for (int i = 0; i < 32; i++) pix(i * 8, i * 3, 255 - i * 8, i == 0, i == 31, "R5");
        idle(2);

        // R8: re-enable, weights written before the disable must be intact
        wr(12, 1);
        for (int i = 0; i < 32; i++) pix(i * 8, 255 - i * 6, i * 5, i == 0, i == 31, "R8");
        idle(2);

        // R9: spare addresses do nothing
        wr(13, 'h1234);
        wr(14, 'h3FFF);
        wr(15, 'h0000);
        for (int i = 0; i < 32; i++) pix(i * 7, i * 8, 255 - i * 3, i == 0, i == 31, "R9");
        idle(8);

        chk(eq_cyc.size() == 0, "R1", "pending outputs at end", eq_cyc.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule